// File: doc/BRIEF.md
# Reference Frequency Offset Monitor

The block checks the frequency of several reference clocks against a local sampling clock that is taken to be accurate. Each reference is brought into the local domain through a two-flop synchroniser, and its rising edges are counted over a fixed gate of local clock cycles. When a gate closes, each reference's count is compared with a nominal count widened by a tolerance derived from a parts-per-million limit (12 ppm by default). The result is registered as one alarm flag per reference, and the flag holds until the next gate closes.

The gate length, the nominal count and the ppm limit are parameters. With the default values the gate is two seconds of a 125 MHz clock. A simulation can use a short gate and a small nominal count instead. The references are judged independently of each other. Choosing which reference to use is left to the surrounding logic.

Top module: `ref_freq_mon`

## Requirements
- R1: Each reference input `ref_in[i]` drives its own flag `alarm[i]`. The count and the verdict for one reference do not depend on any other reference.
- R2: While `rst_n` is low every flag is 0. After `rst_n` rises, every flag stays 0 until the first gate closes, whatever the references do.
- R3: A gate is GATE_CYCLES local clock cycles long. Gate k closes on the rising clock edge that is (k*GATE_CYCLES) edges after reset release, and the flags may change only on that edge. At every other edge they hold their value.
- R4: The tolerance in counts is NOMINAL_COUNT*PPM_LIMIT/1000000, rounded down. If that result is below 1, the tolerance is 1.
- R5: A reference whose gate count lies between NOMINAL_COUNT-tolerance and NOMINAL_COUNT+tolerance, both ends included, has its flag set to 0 when the gate closes.
- R6: A gate count below NOMINAL_COUNT-tolerance or above NOMINAL_COUNT+tolerance sets the flag to 1. Both directions are treated the same way.
- R7: A reference that shows no rising edge during a gate has its flag set to 1 when the gate closes.
- R8: A rising edge is counted once it has passed the two-flop synchroniser, provided each level is held for at least one local clock cycle. The count rises by at most 1 per cycle, saturates at its maximum, and restarts from 0 for each new gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local high-accuracy sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NUM_REFS | Reference clock inputs, asynchronous to `clk` |
| alarm | output | NUM_REFS | Per-reference out-of-window flag, registered once per gate |

## Verification
The flags change only on the edge that closes a gate, GATE_CYCLES edges after the previous close, so each verdict is sampled on the falling edge that directly follows that close. Each hold check samples one cycle before the close and again in mid-gate, where the previous verdict must still be shown. Reference pulses are placed well inside each gate, so the three cycles of synchroniser and edge-detect delay can never move an edge into the next gate. Count boundaries are therefore exact: counts of 999, 1001, 998 and 1002 are used against a window of 1000±1.

// File: rtl/ref_freq_mon_pkg.sv
package ref_freq_mon_pkg;

  // Tolerance in counts for a ppm limit: rounded down, at least one count.
  function automatic longint tol_counts(input longint nominal, input longint ppm);
    longint t;
    t = (nominal * ppm) / 64'sd1000000;
    if (t < 1) t = 1;
    return t;
  endfunction

  // Verdict for one closed gate: 1 when the count leaves the window or is zero.
  function automatic logic window_miss(input longint count, input longint nominal,
                                       input longint tol);
    if (count == 0) return 1'b1;
    if (count < nominal - tol) return 1'b1;
    if (count > nominal + tol) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ref_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int GATE_CYCLES = 4000,
  localparam int GATE_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end
);
  localparam logic [GATE_W-1:0] LAST = GATE_W'(GATE_CYCLES - 1);
  logic [GATE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= '0;
    else if (gate_end)   phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end

  assign gate_end = (phase_q == LAST);
endmodule

// File: rtl/gate_edge_counter.sv
module gate_edge_counter
  import ref_freq_mon_pkg::*;
#(
  parameter int CNT_W         = 12,
  parameter int NOMINAL_COUNT = 1000,
  parameter int PPM_LIMIT     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             gate_end,
  output logic [CNT_W-1:0] count,
  output logic             alarm
);
  localparam longint TOL = tol_counts(longint'(NOMINAL_COUNT), longint'(PPM_LIMIT));
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] total;

  // Edge seen on the closing cycle still belongs to the closing gate.
  always_comb begin
    if (rise && count != CNT_MAX) total = count + 1'b1;
    else                          total = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      alarm <= 1'b0;
    end else if (gate_end) begin
      count <= '0;
      alarm <= window_miss(longint'(total), longint'(NOMINAL_COUNT), TOL);
    end else begin
      count <= total;
    end
  end
endmodule

// File: rtl/ref_freq_mon.sv
module ref_freq_mon #(
  parameter int NUM_REFS      = 2,
  parameter int GATE_CYCLES   = 250_000_000,
  parameter int NOMINAL_COUNT = 38_880_000,
  parameter int PPM_LIMIT     = 12,
  localparam int CNT_W        = $clog2(GATE_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_in,
  output logic [NUM_REFS-1:0] alarm
);
  logic                           gate_end;
  logic [NUM_REFS-1:0]            rise_vec;
  logic [NUM_REFS-1:0][CNT_W-1:0] ref_count;

  gate_timer #(.GATE_CYCLES(GATE_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .gate_end(gate_end)
  );

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    ref_edge_sync sync_i (
      .clk(clk), .rst_n(rst_n), .ref_async(ref_in[g]), .rise(rise_vec[g])
    );
    gate_edge_counter #(
      .CNT_W(CNT_W), .NOMINAL_COUNT(NOMINAL_COUNT), .PPM_LIMIT(PPM_LIMIT)
    ) cnt_i (
      .clk(clk), .rst_n(rst_n), .rise(rise_vec[g]), .gate_end(gate_end),
      .count(ref_count[g]), .alarm(alarm[g])
    );
  end
endmodule

// File: rtl/ref_freq_mon_chk.sv
module ref_freq_mon_chk #(
  parameter int NUM_REFS      = 2,
  parameter int GATE_CYCLES   = 4000,
  parameter int NOMINAL_COUNT = 1000,
  parameter int CNT_W         = 12
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           gate_end,
  input logic [NUM_REFS-1:0]            rise_vec,
  input logic [NUM_REFS-1:0][CNT_W-1:0] ref_count,
  input logic [NUM_REFS-1:0]            alarm
);
  int unsigned since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        since_q <= 0;
    else if (gate_end) since_q <= 0;
    else               since_q <= since_q + 1;
  end

  // R3: a gate closes exactly GATE_CYCLES cycles after the previous one
  assert_gate_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |-> (since_q == GATE_CYCLES - 1));

  // R2: flags are low whenever reset is applied
  assert_reset_low_R2: assert property (@(posedge clk)
    !rst_n |-> (alarm == '0));

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_chk
    // R3: no flag change between gate closes
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_end |=> $stable(alarm[g]));

    // R5: exactly nominal count clears the flag
    assert_nominal_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_end && (int'(ref_count[g]) + int'(rise_vec[g]) == NOMINAL_COUNT)) |=> !alarm[g]);

    // R7: a silent reference raises its flag
    assert_zero_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_end && ref_count[g] == '0 && !rise_vec[g]) |=> alarm[g]);

    // R8: count grows by at most one per cycle inside a gate
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_end |=> (ref_count[g] == $past(ref_count[g]) ||
                     ref_count[g] == $past(ref_count[g]) + 1'b1));

    // R8: count restarts after each close
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> (ref_count[g] == '0));
  end
endmodule

bind ref_freq_mon ref_freq_mon_chk #(
  .NUM_REFS(NUM_REFS), .GATE_CYCLES(GATE_CYCLES),
  .NOMINAL_COUNT(NOMINAL_COUNT), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_end(gate_end),
  .rise_vec(rise_vec), .ref_count(ref_count), .alarm(alarm)
);

// File: tb/ref_freq_mon_tb_top.sv
module ref_freq_mon_tb_top;
  localparam int G    = 4000;
  localparam int NOM  = 1000;
  localparam int PPM  = 12;
  localparam int OFS  = 20;
  localparam int NVEC = 8;

  // {edges ref0, edges ref1, expected alarm0, expected alarm1}; window 1000 +/- 1
  localparam int VEC [NVEC][4] = '{
    '{1000, 1000, 0, 0},
    '{ 999, 1001, 0, 0},
    '{ 998, 1002, 1, 1},
    '{   0, 1000, 1, 0},
    '{1000, 1500, 0, 1},
    '{1001,  999, 0, 0},
    '{ 500,    0, 1, 1},
    '{1000,  900, 0, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_in = 2'b00;
  logic [1:0] alarm;
  int n_checks = 0;
  int n_fail = 0;
  int tol;
  logic [1:0] prev_exp;
  bit done = 0;

  always #4 clk = ~clk;

  ref_freq_mon #(.NUM_REFS(2), .GATE_CYCLES(G), .NOMINAL_COUNT(NOM), .PPM_LIMIT(PPM))
    dut_i (.clk(clk), .rst_n(rst_n), .ref_in(ref_in), .alarm(alarm));

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One full gate of stimulus; the caller stands on the negedge of a gate start.
  task automatic run_gate(input int k0, input int k1, input logic [1:0] hold_exp,
                          input string hold_req);
    for (int i = 1; i <= G; i++) begin
      @(negedge clk);
      ref_in[0] = (i >= OFS) && (i < OFS + 2*k0) && (((i - OFS) % 2) == 0);
      ref_in[1] = (i >= OFS) && (i < OFS + 2*k1) && (((i - OFS) % 2) == 0);
      if (i == G/2 || i == G-1) check(hold_req, alarm, hold_exp);
    end
  endtask

  initial begin
    tol = (NOM * PPM) / 1000000;
    if (tol < 1) tol = 1;
    repeat (3) @(negedge clk);
    check("R2 reset", alarm, 2'b00);
    rst_n = 1'b1;
    // R2: both silent in gate 1, flags still low before the close
    run_gate(0, 0, 2'b00, "R2 before first close");
    check("R7 silent refs", alarm, 2'b11);
    prev_exp = 2'b11;
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] e;
      e = {VEC[v][3] != 0, VEC[v][2] != 0};
      // R4/R5/R6 window bounds; R1 independent flags; R3 hold
      if ((VEC[v][0] >= NOM - tol && VEC[v][0] <= NOM + tol) != (VEC[v][2] == 0) && VEC[v][0] != 0)
        $display("table entry %0d inconsistent with tolerance", v);
      run_gate(VEC[v][0], VEC[v][1], prev_exp, "R3 hold");
      check((v == 1 || v == 5) ? "R5 edge of window" :
            (v == 2) ? "R6 just outside window" :
            (v == 3 || v == 6) ? "R7/R1 silent ref" : "R1 independent verdict",
            alarm, e);
      prev_exp = e;
    end
    // R2: reset in mid-gate clears flags and restarts the gate
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset mid-run", alarm, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_gate(1000, 0, 2'b00, "R2 low until first close");
    check("R8 restart after reset", alarm, 2'b10);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule